// File: doc/BRIEF.md
# Programmable Dual-Modulus Feedback Divider

This block is the feedback divider of a frequency synthesizer loop. It divides a fast input clock by any integer from 495 to 550 and emits one single-cycle pulse on its output per divided period. The ratio arrives as one binary word equal to the wanted division ratio. The upper bits of that word form the program count and the low four bits form the swallow count.

Internally, a 4/5 stage nests inside a 16/17 stage. The 16/17 stage feeds two counters. The swallow counter keeps the 16/17 stage in its divide-by-17 mode for the first S prescaler periods of each output period. It steps down on the falling transition of the prescaler output, which lets a swallow count of one work. The program counter counts P prescaler periods. Its terminal-count decision passes through an extra register, so the compare is made one prescaler period early. The ratio word is taken only when an output period closes, so a change never cuts a period short.

Top module: `ds_divider`

## Requirements
- R1: For every ratio word N from 495 to 550, successive output pulses are exactly N input-clock rising edges apart.
- R2: The ratio word splits into P = bits [9:4] and S = bits [3:0]. In each output period the first S prescaler periods last 17 input cycles and the remaining P − S last 16.
- R3: With S = 0 (N = 496, 512, 528, 544) no prescaler period is stretched, and the output period is exactly 16·P.
- R4: With S = 1 exactly one prescaler period is stretched, and the output period is 16·P + 1.
- R5: `div_out` is high for exactly one input-clock cycle per output period.
- R6: A ratio word changed after a pulse leaves the period already in progress at the old ratio. The following period uses the new ratio.
- R7: While `rst_n` is low, `div_out` is low. After a synchronous release, the first pulse is driven at rising edge N+1 counted from the release.
- R8: The 4/5 stage completes sub-periods of 4 or 5 cycles only, and at most one 5-cycle sub-period occurs per prescaler period.
- R9: The program counter's registered terminal count closes the output period only when the count has reached zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Fast input clock to be divided |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ratio | input | 10 | Division ratio N = 16·P + S, valid 495 to 550 |
| div_out | output | 1 | One-cycle pulse per divided period |

## Verification
A pulse is registered: it is driven on the rising edge after the last cycle of its period. The first pulse after reset therefore lands on rising edge N+1, and each later pulse lands N edges after the one before it. The bench counts rising edges from the reset release. It samples `div_out` on falling edges, so each pulse is seen once, and it compares edge-count differences against N. A ratio change is applied just after an observed pulse. For that reason the next interval is checked against the old ratio and only the interval after it against the new one.

// File: rtl/ds_pkg.sv
package ds_pkg;
  localparam int unsigned RATIO_W = 10;
  localparam int unsigned SWAL_W  = 4;
  localparam int unsigned PROG_W  = RATIO_W - SWAL_W;
  localparam int unsigned SUB_CNT = 4;
  localparam int unsigned SUB_W   = $clog2(SUB_CNT);
  localparam int unsigned QTR_W   = 3;

  typedef struct packed {
    logic [PROG_W-1:0] prog;
    logic [SWAL_W-1:0] swal;
  } ratio_t;
endpackage

// File: rtl/ds_pre45.sv
module ds_pre45
  import ds_pkg::*;
(
  input  logic clk_in,
  input  logic rst_n,
  input  logic load,
  input  logic load5,
  output logic sub_end
);
  logic [QTR_W-1:0] q_q, q_d;

  assign sub_end = (q_q == '0);

  always_comb begin
    q_d = q_q - 1'b1;
    if (load || sub_end) begin
      q_d = load5 ? QTR_W'(4) : QTR_W'(3);
    end
  end

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) q_q <= '0;
    else        q_q <= q_d;
  end
endmodule

// File: rtl/ds_pre1617.sv
module ds_pre1617
  import ds_pkg::*;
(
  input  logic clk_in,
  input  logic rst_n,
  input  logic restart,
  input  logic mc,
  output logic prd_end,
  output logic prd_fall
);
  logic [SUB_W-1:0] sub_q, sub_d;
  logic             sub_end;
  logic             sub_en;
  logic             load5;

  assign prd_end  = sub_end && (sub_q == SUB_W'(SUB_CNT - 1));
  assign prd_fall = sub_end && (sub_q == SUB_W'(SUB_CNT / 2 - 1));
  assign load5    = (restart || prd_end) && mc;
  assign sub_en   = restart || sub_end;

  ds_pre45 u_pre45 (
    .clk_in  (clk_in),
    .rst_n   (rst_n),
    .load    (restart),
    .load5   (load5),
    .sub_end (sub_end)
  );

  always_comb begin
    sub_d = sub_q;
    if (sub_en) sub_d = restart ? '0 : sub_q + 1'b1;
  end

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) sub_q <= '0;
    else        sub_q <= sub_d;
  end
endmodule

// File: rtl/ds_counters.sv
module ds_counters
  import ds_pkg::*;
(
  input  logic              clk_in,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              prd_end,
  input  logic              prd_fall,
  input  ratio_t            ratio,
  output logic              mc,
  output logic              frame_end,
  output logic              load,
  output logic [PROG_W-1:0] prog_cnt,
  output logic [SWAL_W-1:0] swal_cnt,
  output logic              tc
);
  logic [PROG_W-1:0] prog_q, prog_d;
  logic [SWAL_W-1:0] swal_q, swal_d;
  logic              tc_q, tc_d;
  logic              prog_en, swal_en;

  assign frame_end = prd_end && tc_q;
  assign load      = restart || frame_end;
  assign prog_en   = load || prd_end;
  assign swal_en   = load || (prd_fall && (swal_q != '0));

  always_comb begin
    prog_d = prog_q;
    tc_d   = tc_q;
    if (prog_en) begin
      if (load) begin
        prog_d = ratio.prog - 1'b1;
        tc_d   = 1'b0;
      end else begin
        prog_d = prog_q - 1'b1;
        tc_d   = (prog_q == PROG_W'(1));
      end
    end
  end

  always_comb begin
    swal_d = swal_q;
    if (swal_en) swal_d = load ? ratio.swal : swal_q - 1'b1;
  end

  assign mc = (swal_d != '0);

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) begin
      prog_q <= '0;
      swal_q <= '0;
      tc_q   <= 1'b0;
    end else begin
      prog_q <= prog_d;
      swal_q <= swal_d;
      tc_q   <= tc_d;
    end
  end

  assign prog_cnt = prog_q;
  assign swal_cnt = swal_q;
  assign tc       = tc_q;
endmodule

// File: rtl/ds_divider.sv
module ds_divider
  import ds_pkg::*;
#(
  parameter int unsigned RW = RATIO_W
) (
  input  logic          clk_in,
  input  logic          rst_n,
  input  logic [RW-1:0] ratio,
  output logic          div_out
);
  logic              start_q;
  logic              div_q;
  logic              mc, prd_end, prd_fall, frame_end, load, tc;
  logic [PROG_W-1:0] prog_cnt;
  logic [SWAL_W-1:0] swal_cnt;
  ratio_t            ratio_s;

  assign ratio_s = ratio_t'(ratio[RATIO_W-1:0]);

  ds_pre1617 u_pre (
    .clk_in   (clk_in),
    .rst_n    (rst_n),
    .restart  (load),
    .mc       (mc),
    .prd_end  (prd_end),
    .prd_fall (prd_fall)
  );

  ds_counters u_cnt (
    .clk_in    (clk_in),
    .rst_n     (rst_n),
    .restart   (start_q),
    .prd_end   (prd_end),
    .prd_fall  (prd_fall),
    .ratio     (ratio_s),
    .mc        (mc),
    .frame_end (frame_end),
    .load      (load),
    .prog_cnt  (prog_cnt),
    .swal_cnt  (swal_cnt),
    .tc        (tc)
  );

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b1;
      div_q   <= 1'b0;
    end else begin
      start_q <= 1'b0;
      div_q   <= frame_end;
    end
  end

  assign div_out = div_q;
endmodule

// File: rtl/ds_divider_chk.sv
module ds_divider_chk
  import ds_pkg::*;
(
  input logic              clk_in,
  input logic              rst_n,
  input logic              div_out,
  input logic              load,
  input logic              frame_end,
  input logic [PROG_W-1:0] prog_cnt,
  input logic [SWAL_W-1:0] swal_cnt
);
  logic [10:0] gap_q;
  logic        seen_q;

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      if (div_out) begin
        gap_q  <= 11'd1;
        seen_q <= 1'b1;
      end else if (gap_q != '1) begin
        gap_q  <= gap_q + 1'b1;
      end
    end
  end

  p_period_range_r1: assert property (@(posedge clk_in) disable iff (!rst_n)
    (div_out && seen_q) |-> (gap_q >= 11'd495 && gap_q <= 11'd550));

  p_pulse_single_r5: assert property (@(posedge clk_in) disable iff (!rst_n)
    div_out |=> !div_out);

  p_swallow_down_r2: assert property (@(posedge clk_in) disable iff (!rst_n)
    !load |=> (swal_cnt <= $past(swal_cnt)));

  p_tc_at_zero_r9: assert property (@(posedge clk_in) disable iff (!rst_n)
    frame_end |-> (prog_cnt == '0));
endmodule

bind ds_divider ds_divider_chk u_chk (
  .clk_in    (clk_in),
  .rst_n     (rst_n),
  .div_out   (div_out),
  .load      (load),
  .frame_end (frame_end),
  .prog_cnt  (prog_cnt),
  .swal_cnt  (swal_cnt)
);

// File: tb/ds_divider_bench.sv
module ds_divider_bench;
  logic       clk_in;
  logic       rst_n;
  logic [9:0] ratio;
  logic       div_out;

  int edge_cnt;
  int n_chk;
  int n_fail;
  bit done;

  localparam int NV = 8;
  localparam int VEC [NV][2] = '{
    '{495, 495}, '{496, 496}, '{511, 511}, '{512, 512},
    '{513, 513}, '{528, 528}, '{529, 529}, '{550, 550}
  };

  ds_divider u_ds_divider (
    .clk_in  (clk_in),
    .rst_n   (rst_n),
    .ratio   (ratio),
    .div_out (div_out)
  );

  initial clk_in = 1'b0;
  always #4 clk_in = ~clk_in;

  always @(posedge clk_in) if (rst_n) edge_cnt <= edge_cnt + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_pulse(output int at);
    at = -1;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk_in);
      if (div_out) begin
        at = edge_cnt;
        break;
      end
    end
    if (at < 0) chk(1'b0, "R1 watchdog no pulse", 0, 1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(8 * 190000);
    chk(1'b0, "R1 global watchdog", 0, 1);
    finish_run();
  end

  initial begin
    int prev, t1, t2, base, oldn;
    edge_cnt = 0; n_chk = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0;
    ratio = 10'd500;
    repeat (5) @(negedge clk_in);
    chk(div_out == 1'b0, "R7 low in reset", div_out, 0);
    rst_n = 1'b1;
    base = edge_cnt;
    wait_pulse(t1);
    chk(t1 - base == 501, "R7 first pulse edge", t1 - base, 501);
    @(negedge clk_in);
    chk(div_out == 1'b0, "R5 pulse width", div_out, 0);
    prev = t1;
    oldn = 500;

    // table of ratio / expected period
    for (int v = 0; v < NV; v++) begin
      ratio = 10'(VEC[v][0]);
      wait_pulse(t1);
      chk(t1 - prev == oldn, "R6 old ratio kept", t1 - prev, oldn);
      wait_pulse(t2);
      chk(t2 - t1 == VEC[v][1], "R1 R2 R8 R9 table period", t2 - t1, VEC[v][1]);
      @(negedge clk_in);
      chk(div_out == 1'b0, "R5 pulse width", div_out, 0);
      prev = t2;
      oldn = VEC[v][1];
    end

    // full sweep of every ratio
    for (int n = 495; n <= 550; n++) begin
      ratio = 10'(n);
      wait_pulse(t1);
      chk(t1 - prev == oldn, "R6 old ratio kept", t1 - prev, oldn);
      wait_pulse(t2);
      if ((n % 16) == 0)      chk(t2 - t1 == n, "R3 swallow zero", t2 - t1, n);
      else if ((n % 16) == 1) chk(t2 - t1 == n, "R4 swallow one", t2 - t1, n);
      else                    chk(t2 - t1 == n, "R1 sweep period", t2 - t1, n);
      prev = t2;
      oldn = n;
    end

    // reset in the middle of a period
    repeat (100) @(negedge clk_in);
    rst_n = 1'b0;
    ratio = 10'd530;
    repeat (3) @(negedge clk_in);
    chk(div_out == 1'b0, "R7 low in mid reset", div_out, 0);
    rst_n = 1'b1;
    base = edge_cnt;
    wait_pulse(t1);
    chk(t1 - base == 531, "R7 first pulse after mid reset", t1 - base, 531);
    wait_pulse(t2);
    chk(t2 - t1 == 530, "R1 period after reset", t2 - t1, 530);

    finish_run();
  end
endmodule